// File: doc/BRIEF.md
# Span Texture Coordinate Stepper

This block turns one span descriptor into a stream of per-pixel coordinates. A descriptor carries a starting line-buffer column, a pixel count, starting S and T texture coordinates in fixed point, per-pixel S and T increments, a scale enable and a horizontal mirror flag. After a descriptor is taken, the block presents one pixel per accepted output beat. Each beat carries the line-buffer column and the S/T coordinates for that pixel. The block then moves the column by one, forward or backward, and steps S and T for the next pixel. Address generation, fetching and blending sit downstream and are not part of it.

S and T are unsigned fixed-point values `CW` bits wide, with `FRACW` fraction bits below the integer part. With the default widths, the integer part starts at bit 6 and bits 19 down to 6 are the ones a downstream stage uses for indexing. With scaling off, S moves by exactly one whole texel per pixel and T stays put. With scaling on, S moves by the programmed dS/dx and T by the programmed dT/dx. Together these give magnification, minification and rotated, diagonal walks. When mirrored, the column counts down and S is walked backwards. The caller supplies the S of the last texel of the row as the start.

Both sides are valid/ready. The descriptor side accepts on `span_valid && span_ready`. `span_ready` is high whenever no span is in flight, and also in the cycle the final pixel of the current span is accepted, so spans can run back to back without a bubble. The pixel side transfers on `pix_valid && pix_ready`. While `pix_ready` is low, every output and all internal state hold. A span that has been accepted cannot be withdrawn. A descriptor must hold its fields while `span_valid` is high and `span_ready` is low.

Top module: `span_coord_stepper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pix_valid` is 0 and `span_ready` is 1.
- R2: A descriptor with nonzero length accepted at a clock edge makes `pix_valid` 1 from the next cycle on. Exactly `span_len` pixel transfers then take place for that span.
- R3: Within a span, each accepted pixel is followed by one whose column `pix_x` is one higher (modulo 2^XW), or one lower when the mirror flag was set.
- R4: With scaling off, S changes by exactly one whole texel (1 << FRACW, i.e. bit 6 by default) per pixel: added, or subtracted when mirrored. T keeps its start value and dT/dx has no effect.
- R5: With scaling on, dS/dx is added to S per pixel, or subtracted when mirrored. dT/dx (two's complement) is added to T per pixel. Both wrap modulo 2^CW.
- R6: `pix_last` is 1 on the final pixel of a span and 0 on every other pixel.
- R7: While `pix_valid` is 1 and `pix_ready` is 0, `pix_valid`, `pix_x`, `pix_s`, `pix_t` and `pix_last` hold their values into the next cycle.
- R8: A descriptor of length 0 is accepted and yields no pixel. In the next cycle `pix_valid` is 0 and `span_ready` is 1.
- R9: `span_ready` is 1 exactly when no pixel is pending, or when the pending pixel is the last one and `pix_ready` is 1.
- R10: The first pixel of a span carries the descriptor's start column, start S and start T unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| span_valid | input | 1 | Descriptor offered |
| span_ready | output | 1 | Descriptor can be taken this cycle |
| span_x | input | XW | Start line-buffer column |
| span_len | input | LW | Number of pixels in the span |
| span_s | input | CW | Start S, fixed point with FRACW fraction bits |
| span_t | input | CW | Start T, fixed point with FRACW fraction bits |
| span_dsdx | input | CW | S increment per pixel when scaling is on |
| span_dtdx | input | CW | T increment per pixel when scaling is on, two's complement |
| span_scale | input | 1 | Use the programmed increments instead of unit stepping |
| span_reflect | input | 1 | Mirror: column counts down, S is walked backwards |
| pix_valid | output | 1 | A pixel is presented |
| pix_ready | input | 1 | Downstream takes the pixel |
| pix_x | output | XW | Line-buffer column of the pixel |
| pix_s | output | CW | S coordinate of the pixel |
| pix_t | output | CW | T coordinate of the pixel |
| pix_last | output | 1 | Pixel is the final one of its span |

## Verification
A wrong remaining-count shows up within one span: pix_last lands on the wrong beat, too many or too few pixels appear, and span_ready rises early or late. A wrong stored increment or direction corrupts S, T or the column on the second pixel of the span, the first beat after the start value. A stall that leaks into state shows as a coordinate that skips a step on the beat after pix_ready returns. Comparing every beat against a behavioural model running under random back-pressure catches each of these on the first pixel it affects.

// File: rtl/span_step_pkg.sv
package span_step_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int LANE_S = 0;
  localparam int LANE_T = 1;
  localparam int NUM_TEX_LANES = 2;

endpackage

// File: rtl/span_seq_ctrl.sv
module span_seq_ctrl
  import span_step_pkg::*;
#(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [LW-1:0] req_len,
  output logic          req_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_last,
  output logic          load,
  output logic          step
);

  seq_state_e    state;
  logic [LW-1:0] remain;
  logic          accept;
  logic          beat;

  assign out_valid = (state == SEQ_RUN);
  assign out_last  = out_valid && (remain == LW'(1));
  assign beat      = out_valid && out_ready;
  assign req_ready = !out_valid || (out_last && out_ready);
  assign accept    = req_valid && req_ready;
  assign load      = accept && (req_len != '0);
  assign step      = beat && !out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      remain <= '0;
    end else if (load) begin
      state  <= SEQ_RUN;
      remain <= req_len;
    end else if (beat) begin
      if (out_last) begin
        state <= SEQ_IDLE;
      end
      remain <= remain - LW'(1);
    end
  end

endmodule

// File: rtl/coord_lane.sv
module coord_lane #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic [W-1:0] inc,
  input  logic         down,
  input  logic         step,
  output logic [W-1:0] val
);

  logic [W-1:0] inc_q;
  logic         down_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val    <= '0;
      inc_q  <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      val    <= init;
      inc_q  <= inc;
      down_q <= down;
    end else if (step) begin
      if (down_q) begin
        val <= val - inc_q;
      end else begin
        val <= val + inc_q;
      end
    end
  end

endmodule

// File: rtl/span_coord_stepper.sv
module span_coord_stepper
  import span_step_pkg::*;
#(
  parameter int XW    = 10,
  parameter int LW    = 9,
  parameter int CW    = 24,
  parameter int FRACW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          span_valid,
  output logic          span_ready,
  input  logic [XW-1:0] span_x,
  input  logic [LW-1:0] span_len,
  input  logic [CW-1:0] span_s,
  input  logic [CW-1:0] span_t,
  input  logic [CW-1:0] span_dsdx,
  input  logic [CW-1:0] span_dtdx,
  input  logic          span_scale,
  input  logic          span_reflect,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [XW-1:0] pix_x,
  output logic [CW-1:0] pix_s,
  output logic [CW-1:0] pix_t,
  output logic          pix_last
);

  localparam logic [CW-1:0] UNIT_STEP = CW'(1) << FRACW;

  logic load;
  logic step;

  span_seq_ctrl #(.LW(LW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (span_valid),
    .req_len   (span_len),
    .req_ready (span_ready),
    .out_valid (pix_valid),
    .out_ready (pix_ready),
    .out_last  (pix_last),
    .load      (load),
    .step      (step)
  );

  coord_lane #(.W(XW)) u_col (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .init  (span_x),
    .inc   (XW'(1)),
    .down  (span_reflect),
    .step  (step),
    .val   (pix_x)
  );

  logic [CW-1:0] lane_init [NUM_TEX_LANES];
  logic [CW-1:0] lane_inc  [NUM_TEX_LANES];
  logic          lane_down [NUM_TEX_LANES];
  logic [CW-1:0] lane_val  [NUM_TEX_LANES];

  always_comb begin
    lane_init[LANE_S] = span_s;
    lane_inc[LANE_S]  = span_scale ? span_dsdx : UNIT_STEP;
    lane_down[LANE_S] = span_reflect;
    lane_init[LANE_T] = span_t;
    lane_inc[LANE_T]  = span_scale ? span_dtdx : '0;
    lane_down[LANE_T] = 1'b0;
  end

  for (genvar g = 0; g < NUM_TEX_LANES; g++) begin : g_tex
    coord_lane #(.W(CW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .init  (lane_init[g]),
      .inc   (lane_inc[g]),
      .down  (lane_down[g]),
      .step  (step),
      .val   (lane_val[g])
    );
  end

  assign pix_s = lane_val[LANE_S];
  assign pix_t = lane_val[LANE_T];

endmodule

// File: rtl/span_coord_stepper_chk.sv
module span_coord_stepper_chk #(
  parameter int XW    = 10,
  parameter int LW    = 9,
  parameter int CW    = 24,
  parameter int FRACW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          span_valid,
  input logic          span_ready,
  input logic [XW-1:0] span_x,
  input logic [LW-1:0] span_len,
  input logic [CW-1:0] span_s,
  input logic [CW-1:0] span_t,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [XW-1:0] pix_x,
  input logic [CW-1:0] pix_s,
  input logic [CW-1:0] pix_t,
  input logic          pix_last
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!pix_valid && span_ready)); // R1

  AST_START_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    (span_valid && span_ready && span_len != '0) |=>
      (pix_valid && pix_x == $past(span_x) && pix_s == $past(span_s) && pix_t == $past(span_t))); // R10

  AST_COLUMN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && !pix_last) |=>
      (pix_x == XW'($past(pix_x) + XW'(1)) || pix_x == XW'($past(pix_x) - XW'(1)))); // R3

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_last && !(span_valid && span_ready)) |=> !pix_valid); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=>
      (pix_valid && $stable(pix_x) && $stable(pix_s) && $stable(pix_t) && $stable(pix_last))); // R7

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (span_valid && span_ready && span_len == '0) |=> (!pix_valid && span_ready)); // R8

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !(pix_ready && pix_last)) |-> !span_ready); // R9

endmodule

bind span_coord_stepper span_coord_stepper_chk #(
  .XW(XW), .LW(LW), .CW(CW), .FRACW(FRACW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .span_valid (span_valid),
  .span_ready (span_ready),
  .span_x     (span_x),
  .span_len   (span_len),
  .span_s     (span_s),
  .span_t     (span_t),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .pix_x      (pix_x),
  .pix_s      (pix_s),
  .pix_t      (pix_t),
  .pix_last   (pix_last)
);

// File: tb/span_coord_stepper_test.sv
`timescale 1ns/1ps
module span_coord_stepper_test;

  localparam int XW = 10;
  localparam int LW = 9;
  localparam int CW = 24;
  localparam int FRACW = 6;
  localparam longint XMASK = (64'sd1 << XW) - 1;
  localparam longint CMASK = (64'sd1 << CW) - 1;
  localparam int CYCLE_LIMIT = 100000;

  typedef struct {
    int     x;
    int     len;
    longint s;
    longint t;
    longint ds;
    longint dt;
    bit     sc;
    bit     rf;
  } span_d;

  typedef struct {
    longint x;
    longint s;
    longint t;
    bit     last;
    bit     first;
    bit     sc;
  } pix_d;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          span_valid;
  logic          span_ready;
  logic [XW-1:0] span_x;
  logic [LW-1:0] span_len;
  logic [CW-1:0] span_s;
  logic [CW-1:0] span_t;
  logic [CW-1:0] span_dsdx;
  logic [CW-1:0] span_dtdx;
  logic          span_scale;
  logic          span_reflect;
  logic          pix_valid;
  logic          pix_ready;
  logic [XW-1:0] pix_x;
  logic [CW-1:0] pix_s;
  logic [CW-1:0] pix_t;
  logic          pix_last;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  span_d pend[$];
  pix_d  expq[$];

  always #2.5 clk = ~clk;

  span_coord_stepper #(.XW(XW), .LW(LW), .CW(CW), .FRACW(FRACW)) uut (
    .clk(clk), .rst_n(rst_n),
    .span_valid(span_valid), .span_ready(span_ready),
    .span_x(span_x), .span_len(span_len), .span_s(span_s), .span_t(span_t),
    .span_dsdx(span_dsdx), .span_dtdx(span_dtdx),
    .span_scale(span_scale), .span_reflect(span_reflect),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_x(pix_x), .pix_s(pix_s), .pix_t(pix_t), .pix_last(pix_last)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic span_d mk(int x, int len, longint s, longint t, longint ds, longint dt,
                               bit sc, bit rf);
    span_d d;
    d.x = x; d.len = len; d.s = s; d.t = t; d.ds = ds; d.dt = dt; d.sc = sc; d.rf = rf;
    return d;
  endfunction

  task automatic expand(span_d d);
    longint step;
    step = d.sc ? d.ds : (64'sd1 << FRACW);
    for (int i = 0; i < d.len; i++) begin
      pix_d p;
      p.x     = (longint'(d.x) + (d.rf ? -i : i)) & XMASK;
      p.s     = (d.s + (d.rf ? -(step * i) : (step * i))) & CMASK;
      p.t     = (d.t + (d.sc ? d.dt * i : 64'sd0)) & CMASK;
      p.last  = (i == d.len - 1);
      p.first = (i == 0);
      p.sc    = d.sc;
      expq.push_back(p);
    end
  endtask

  task automatic run(bit rand_ready);
    bit     prev_stall = 1'b0;
    bit     zl_prev = 1'b0;
    longint px = 0, ps = 0, pt = 0, pl = 0;
    int     start = cyc;
    while ((pend.size() > 0 || expq.size() > 0) && (cyc - start) < CYCLE_LIMIT) begin
      bit exp_valid;
      bit exp_ready;
      @(negedge clk);
      cyc++;
      pix_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
      if (pend.size() > 0) begin
        span_valid   = 1'b1;
        span_x       = XW'(pend[0].x);
        span_len     = LW'(pend[0].len);
        span_s       = CW'(pend[0].s);
        span_t       = CW'(pend[0].t);
        span_dsdx    = CW'(pend[0].ds);
        span_dtdx    = CW'(pend[0].dt);
        span_scale   = pend[0].sc;
        span_reflect = pend[0].rf;
      end else begin
        span_valid = 1'b0;
      end
      #1;
      exp_valid = (expq.size() > 0);
      exp_ready = (expq.size() == 0) || (expq.size() == 1 && pix_ready);
      chk("R2", "pix_valid", longint'(pix_valid), longint'(exp_valid));
      chk("R9", "span_ready", longint'(span_ready), longint'(exp_ready));
      if (zl_prev) begin
        chk("R8", "pix_valid after empty span", longint'(pix_valid), 0);
        chk("R8", "span_ready after empty span", longint'(span_ready), 1);
        zl_prev = 1'b0;
      end
      if (prev_stall) begin
        chk("R7", "held x", longint'(pix_x), px);
        chk("R7", "held s", longint'(pix_s), ps);
        chk("R7", "held t", longint'(pix_t), pt);
        chk("R7", "held last", longint'(pix_last), pl);
      end
      if (exp_valid && pix_ready) begin
        pix_d e;
        e = expq.pop_front();
        chk(e.first ? "R10" : "R3", "pix_x", longint'(pix_x), e.x);
        chk(e.first ? "R10" : (e.sc ? "R5" : "R4"), "pix_s", longint'(pix_s), e.s);
        chk(e.first ? "R10" : (e.sc ? "R5" : "R4"), "pix_t", longint'(pix_t), e.t);
        chk("R6", "pix_last", longint'(pix_last), longint'(e.last));
      end
      prev_stall = exp_valid && !pix_ready;
      px = longint'(pix_x); ps = longint'(pix_s); pt = longint'(pix_t); pl = longint'(pix_last);
      if (span_valid && exp_ready) begin
        span_d d;
        d = pend.pop_front();
        expand(d);
        if (d.len == 0) zl_prev = 1'b1;
      end
    end
    if ((cyc - start) >= CYCLE_LIMIT) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion (cycle %0d)", cyc);
      pend.delete();
      expq.delete();
    end
    @(negedge clk);
    span_valid = 1'b0;
    pix_ready  = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    span_valid = 1'b0; span_x = '0; span_len = '0; span_s = '0; span_t = '0;
    span_dsdx = '0; span_dtdx = '0; span_scale = 1'b0; span_reflect = 1'b0;
    pix_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pix_valid in reset", longint'(pix_valid), 0);
    chk("R1", "span_ready in reset", longint'(span_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pix_valid after reset", longint'(pix_valid), 0);
    chk("R1", "span_ready after reset", longint'(span_ready), 1);

    // R4: unit stepping; scale off with nonzero dT/dx must leave T fixed
    pend.push_back(mk(100, 4, 24'h001040, 24'h000200, 24'h000011, 24'h000033, 1'b0, 1'b0));
    // R3 R4: mirrored, column wraps below zero
    pend.push_back(mk(1, 3, 24'h0FFFC0, 24'h000500, 0, 0, 1'b0, 1'b1));
    // R8: empty span between two others
    pend.push_back(mk(7, 0, 24'h000000, 24'h000000, 0, 0, 1'b0, 1'b0));
    // R6 R10: single pixel
    pend.push_back(mk(50, 1, 24'h123456, 24'h0ABCDE, 24'h000040, 0, 1'b1, 1'b0));
    // R5: magnify by two (half-texel step)
    pend.push_back(mk(200, 6, 24'h000100, 24'h000000, 24'h000020, 0, 1'b1, 1'b0));
    // R5: shrink, step 2.5 texels, mirrored
    pend.push_back(mk(300, 5, 24'h004000, 24'h000000, 24'h0000A0, 0, 1'b1, 1'b1));
    // R5: rotation, T walks down
    pend.push_back(mk(400, 7, 24'h002000, 24'h003000, 24'h00003A, -64'sd23, 1'b1, 1'b0));
    // R5: S wraps past the top of the register
    pend.push_back(mk(1020, 6, 24'hFFFF80, 24'hFFFFF0, 24'h000050, 24'h000011, 1'b1, 1'b0));
    run(1'b0);

    for (int k = 0; k < 40; k++) begin
      pend.push_back(mk($urandom % 1024, $urandom % 18, longint'($urandom) & CMASK,
                        longint'($urandom) & CMASK, longint'($urandom % 512),
                        longint'($signed($urandom % 256) - 128), 1'($urandom), 1'($urandom)));
    end
    run(1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule